// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the byte-wide arithmetic unit of an accumulator-oriented microcontroller core. For the operation selected on `op_sel`, it combines the accumulator byte `acc_in` with a second operand byte `opnd_in`. It computes the result byte and the next carry, half-carry, overflow and parity values in the same cycle. It also drives a mask that shows which of the three stored arithmetic flags the operation is allowed to change. The operations are:

- add
- add including the stored carry
- subtract including the stored borrow
- increment
- decrement
- packed-BCD decimal adjust

The block also owns the 8-bit status word. The status word holds:

- the carry and half-carry flags
- a free user flag
- a two-bit register-bank select
- the overflow flag
- a reserved bit that always reads 0
- the accumulator parity

Software may load the status word through a write port. The parity bit cannot be loaded this way: it is refreshed on every clock from the accumulator value presented on `acc_in`. When `exec_en` is high, the arithmetic flags are captured under the mask.

Top module: `byte_alu_status`

## Requirements
- R1: With op code 0 (add), `res_out` is (A+B) mod 256. `cy_nxt` is the carry out of bit 7. `ac_nxt` is the carry from bit 3 into bit 4. `ov_nxt` is 1 when the signed sum is outside -128..127. `flag_we` = 3'b111 ({CY,AC,OV}).
- R2: With op code 1 (add with carry), the stored CY (status bit 7) is a third addend of the same sum. The flag rules and mask are the same as in R1.
- R3: With op code 2 (subtract with borrow), `res_out` is (A-B-CY) mod 256. `cy_nxt` is 1 on a borrow out of bit 7. `ac_nxt` is 1 when the low nibble needs a borrow. `ov_nxt` is 1 when the signed difference is outside -128..127. `flag_we` = 3'b111.
- R4: Op code 3 gives (A+1) mod 256 and op code 4 gives (A-1) mod 256. Both drive `flag_we` = 0 and leave status bits 7:2 unchanged when executed.
- R5: With op code 5 (decimal adjust), the block first adds 06h when the low nibble is above 9 or stored AC (status bit 6) is 1. It then adds 60h when the high nibble of that intermediate value is above 9, or stored CY is 1, or the first step carried out.
- R6: Decimal adjust drives `flag_we` = 3'b100. Its `cy_nxt` is the stored CY ORed with the carry out of either step, so CY is never cleared by it. OV (status bit 2) and AC stay unchanged.
- R7: `p_nxt` is the XOR of the bits of `res_out`. Status bit 0 takes the XOR of `acc_in` on every clock after reset, whatever is written to that bit.
- R8: The status layout is CY bit 7, AC bit 6, user flag bit 5, bank select bits 4:3, OV bit 2, reserved bit 1, parity bit 0. Bit 1 always reads 0, whatever is written to it.
- R9: On a clock with `exec_en` high and `sw_wr` low, status bits CY/AC/OV whose `flag_we` bit is set load `cy_nxt`/`ac_nxt`/`ov_nxt`. All other status bits 7:2 keep their value. With neither strobe high, bits 7:2 hold.
- R10: When `sw_wr` is high, status bits 7:2 load `sw_wdata[7:2]`, even if `exec_en` is also high.
- R11: Op codes 6 and 7 pass `acc_in` to `res_out` unchanged, with `flag_we` = 0.
- R12: Reset is synchronous and active-high and sets the status word to 00h. A software write in a reset cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation code |
| acc_in | input | 8 | Accumulator byte (first operand, parity source) |
| opnd_in | input | 8 | Second operand byte |
| exec_en | input | 1 | Capture masked flags into the status word |
| sw_wr | input | 1 | Software write strobe for the status word |
| sw_wdata | input | 8 | Software write data |
| res_out | output | 8 | Result byte |
| cy_nxt | output | 1 | Next carry/borrow flag |
| ac_nxt | output | 1 | Next half-carry flag |
| ov_nxt | output | 1 | Next overflow flag |
| p_nxt | output | 1 | Parity of the result byte |
| flag_we | output | 3 | Update mask {CY,AC,OV} |
| psw_q | output | 8 | Status word |

## Verification
A flag capture from an executed operation and a software load of the status word can fall on the same clock edge. At the same time, the parity bit is refreshed from the accumulator. The random stimulus raises `exec_en` and `sw_wr` independently, so both strobes are often high together. A directed case also executes an add that would set carry and overflow while software writes zeros. The bench's status model gives the software write precedence for bits 7:2, recomputes parity from `acc_in` and forces bit 1 to 0. The register is compared with this model after every edge.

// File: rtl/balu_pkg.sv
package balu_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int OP_W   = 3;
    localparam int NFLAG  = 3;

    // status word bit positions
    localparam int SB_CY  = 7;
    localparam int SB_AC  = 6;
    localparam int SB_UF  = 5;
    localparam int SB_BK1 = 4;
    localparam int SB_BK0 = 3;
    localparam int SB_OV  = 2;
    localparam int SB_RSV = 1;
    localparam int SB_PAR = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUBB = 3'd2,
        OP_INC  = 3'd3,
        OP_DEC  = 3'd4,
        OP_DADJ = 3'd5
    } alu_op_e;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } flags_t;

    typedef struct packed {
        logic [BYTE_W-1:0] res;
        flags_t            fl;
        flags_t            we;
    } alu_out_t;

    localparam flags_t FL_NONE = '{cy: 1'b0, ac: 1'b0, ov: 1'b0};
    localparam flags_t FL_ALL  = '{cy: 1'b1, ac: 1'b1, ov: 1'b1};
    localparam flags_t FL_CY   = '{cy: 1'b1, ac: 1'b0, ov: 1'b0};

    function automatic logic parity_of(input logic [BYTE_W-1:0] v);
        return ^v;
    endfunction

    function automatic logic nib_over9(input logic [NIB_W-1:0] n);
        return n > NIB_W'(9);
    endfunction

endpackage

// File: rtl/balu_arith.sv
module balu_arith
    import balu_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int NW = NIB_W
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output flags_t         fl
);
    logic          sub, cin_e;
    logic [W:0]    full_x;
    logic [NW:0]   nib_x;
    logic [W-1:0]  low_x;
    logic          c_msb_in;

    always_comb begin
        sub   = (op == OP_SUBB);
        cin_e = ((op == OP_ADDC) || (op == OP_SUBB)) ? cin : 1'b0;

        if (sub) begin
            full_x = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin_e};
            nib_x  = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin_e};
            low_x  = {1'b0, a[W-2:0]} - {1'b0, b[W-2:0]} - {{(W-1){1'b0}}, cin_e};
        end else begin
            full_x = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin_e};
            nib_x  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin_e};
            low_x  = {1'b0, a[W-2:0]} + {1'b0, b[W-2:0]} + {{(W-1){1'b0}}, cin_e};
        end
        c_msb_in = low_x[W-1];

        fl.cy = full_x[W];
        fl.ac = nib_x[NW];
        fl.ov = full_x[W] ^ c_msb_in;

        unique case (op)
            OP_INC:  res = a + W'(1);
            OP_DEC:  res = a - W'(1);
            default: res = full_x[W-1:0];
        endcase
    end
endmodule

// File: rtl/balu_decadj.sv
module balu_decadj
    import balu_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int NW = NIB_W
) (
    input  logic [W-1:0] a,
    input  logic         cy_in,
    input  logic         ac_in,
    output logic [W-1:0] res,
    output logic         cy_out
);
    localparam logic [W:0] LO_FIX = (W+1)'(6);
    localparam logic [W:0] HI_FIX = (W+1)'(6) << NW;

    logic          lo_sel, hi_sel;
    logic [W:0]    step1, step2;

    always_comb begin
        lo_sel = nib_over9(a[NW-1:0]) || ac_in;
        step1  = {1'b0, a} + (lo_sel ? LO_FIX : '0);
        hi_sel = nib_over9(step1[W-1:NW]) || cy_in || step1[W];
        step2  = {1'b0, step1[W-1:0]} + (hi_sel ? HI_FIX : '0);
        res    = step2[W-1:0];
        cy_out = cy_in | step1[W] | step2[W];
    end
endmodule

// File: rtl/balu_statreg.sv
module balu_statreg
    import balu_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd_en,
    input  flags_t       fl,
    input  flags_t       we,
    input  logic         sw_wr,
    input  logic [W-1:0] sw_wdata,
    input  logic [W-1:0] acc,
    output logic [W-1:0] psw_q
);
    logic [W-1:0] psw_d;

    always_comb begin
        psw_d = psw_q;
        if (sw_wr) begin
            psw_d[SB_CY]  = sw_wdata[SB_CY];
            psw_d[SB_AC]  = sw_wdata[SB_AC];
            psw_d[SB_UF]  = sw_wdata[SB_UF];
            psw_d[SB_BK1] = sw_wdata[SB_BK1];
            psw_d[SB_BK0] = sw_wdata[SB_BK0];
            psw_d[SB_OV]  = sw_wdata[SB_OV];
        end else if (upd_en) begin
            if (we.cy) psw_d[SB_CY] = fl.cy;
            if (we.ac) psw_d[SB_AC] = fl.ac;
            if (we.ov) psw_d[SB_OV] = fl.ov;
        end
        psw_d[SB_RSV] = 1'b0;
        psw_d[SB_PAR] = parity_of(acc);
    end

    always_ff @(posedge clk) begin
        if (rst) psw_q <= '0;
        else     psw_q <= psw_d;
    end
endmodule

// File: rtl/byte_alu_status.sv
module byte_alu_status
    import balu_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int NW = NIB_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] op_sel,
    input  logic [W-1:0]    acc_in,
    input  logic [W-1:0]    opnd_in,
    input  logic            exec_en,
    input  logic            sw_wr,
    input  logic [W-1:0]    sw_wdata,
    output logic [W-1:0]    res_out,
    output logic            cy_nxt,
    output logic            ac_nxt,
    output logic            ov_nxt,
    output logic            p_nxt,
    output logic [NFLAG-1:0] flag_we,
    output logic [W-1:0]    psw_q
);
    alu_op_e      op;
    logic [W-1:0] ar_res, da_res;
    flags_t       ar_fl;
    logic         da_cy;
    alu_out_t     sel;

    assign op = alu_op_e'(op_sel);

    balu_arith #(.W(W), .NW(NW)) u_arith (
        .op  (op),
        .a   (acc_in),
        .b   (opnd_in),
        .cin (psw_q[SB_CY]),
        .res (ar_res),
        .fl  (ar_fl)
    );

    balu_decadj #(.W(W), .NW(NW)) u_decadj (
        .a      (acc_in),
        .cy_in  (psw_q[SB_CY]),
        .ac_in  (psw_q[SB_AC]),
        .res    (da_res),
        .cy_out (da_cy)
    );

    always_comb begin
        sel.res = acc_in;
        sel.fl  = ar_fl;
        sel.we  = FL_NONE;
        case (op_sel)
            OP_ADD, OP_ADDC, OP_SUBB: begin
                sel.res = ar_res;
                sel.we  = FL_ALL;
            end
            OP_INC, OP_DEC: begin
                sel.res = ar_res;
            end
            OP_DADJ: begin
                sel.res   = da_res;
                sel.fl.cy = da_cy;
                sel.fl.ac = psw_q[SB_AC];
                sel.fl.ov = psw_q[SB_OV];
                sel.we    = FL_CY;
            end
            default: ;
        endcase
    end

    assign res_out = sel.res;
    assign cy_nxt  = sel.fl.cy;
    assign ac_nxt  = sel.fl.ac;
    assign ov_nxt  = sel.fl.ov;
    assign p_nxt   = parity_of(sel.res);
    assign flag_we = sel.we;

    balu_statreg #(.W(W)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (exec_en),
        .fl       (sel.fl),
        .we       (sel.we),
        .sw_wr    (sw_wr),
        .sw_wdata (sw_wdata),
        .acc      (acc_in),
        .psw_q    (psw_q)
    );
endmodule

// File: rtl/balu_chk.sv
module balu_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] op_sel,
    input logic [7:0] acc_in,
    input logic       exec_en,
    input logic       sw_wr,
    input logic [7:0] sw_wdata,
    input logic [7:0] res_out,
    input logic [2:0] flag_we,
    input logic [7:0] psw_q
);
    p_parity_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> psw_q[0] == ^$past(acc_in));

    p_rsv_zero_r8: assert property (@(posedge clk) disable iff (rst)
        psw_q[1] == 1'b0);

    p_sw_prio_r10: assert property (@(posedge clk) disable iff (rst)
        sw_wr |=> psw_q[7:2] == $past(sw_wdata[7:2]));

    p_incdec_noflag_r4: assert property (@(posedge clk) disable iff (rst)
        (exec_en && !sw_wr && (op_sel == 3'd3 || op_sel == 3'd4))
        |=> psw_q[7:2] == $past(psw_q[7:2]));

    p_da_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (exec_en && !sw_wr && op_sel == 3'd5 && psw_q[7])
        |=> psw_q[7] && psw_q[2] == $past(psw_q[2]));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!exec_en && !sw_wr) |=> psw_q[7:2] == $past(psw_q[7:2]));

    p_unused_pass_r11: assert property (@(posedge clk) disable iff (rst)
        (op_sel >= 3'd6) |-> (res_out == acc_in && flag_we == 3'b000));
endmodule

bind byte_alu_status balu_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_sel   (op_sel),
    .acc_in   (acc_in),
    .exec_en  (exec_en),
    .sw_wr    (sw_wr),
    .sw_wdata (sw_wdata),
    .res_out  (res_out),
    .flag_we  (flag_we),
    .psw_q    (psw_q)
);

// File: tb/byte_alu_status_tb.sv
module byte_alu_status_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] acc_in = 8'h00, opnd_in = 8'h00, sw_wdata = 8'h00;
    logic       exec_en = 1'b0, sw_wr = 1'b0;
    logic [7:0] res_out, psw_q;
    logic       cy_nxt, ac_nxt, ov_nxt, p_nxt;
    logic [2:0] flag_we;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] psw_m = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_alu_status u_dut (
        .clk(clk), .rst(rst), .op_sel(op_sel), .acc_in(acc_in),
        .opnd_in(opnd_in), .exec_en(exec_en), .sw_wr(sw_wr),
        .sw_wdata(sw_wdata), .res_out(res_out), .cy_nxt(cy_nxt),
        .ac_nxt(ac_nxt), .ov_nxt(ov_nxt), .p_nxt(p_nxt),
        .flag_we(flag_we), .psw_q(psw_q)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // returns {res[7:0], cy, ac, ov, we_cy, we_ac, we_ov}
    function automatic logic [13:0] ref_alu(input int op, input int a, input int b,
                                            input int cy, input int ac);
        int r, sr, lo, v, c;
        logic f_cy, f_ac, f_ov;
        logic [2:0] m;
        r = a; f_cy = 0; f_ac = 0; f_ov = 0; m = 3'b000;
        case (op)
            0, 1: begin
                c = (op == 1) ? cy : 0;
                r = a + b + c;
                f_cy = (r > 255);
                f_ac = ((a % 16) + (b % 16) + c) > 15;
                sr = int'($signed(8'(a))) + int'($signed(8'(b))) + c;
                f_ov = (sr > 127) || (sr < -128);
                r = r % 256; m = 3'b111;
            end
            2: begin
                f_cy = a < (b + cy);
                f_ac = (a % 16) < ((b % 16) + cy);
                sr = int'($signed(8'(a))) - int'($signed(8'(b))) - cy;
                f_ov = (sr > 127) || (sr < -128);
                r = (a - b - cy + 512) % 256; m = 3'b111;
            end
            3: r = (a + 1) % 256;
            4: r = (a + 255) % 256;
            5: begin
                v = a; c = cy; lo = a % 16;
                if (lo > 9 || ac != 0) v = v + 6;
                if (v > 255) c = 1;
                v = v % 256;
                if ((v / 16) > 9 || c != 0) v = v + 96;
                if (v > 255) c = 1;
                r = v % 256; f_cy = c[0]; m = 3'b100;
            end
            default: r = a;
        endcase
        return {8'(r), f_cy, f_ac, f_ov, m};
    endfunction

    task automatic step(input int op, input int a, input int b, input bit ex,
                        input bit wr, input int wd, input string tag);
        logic [13:0] e;
        logic [7:0]  nx;
        @(negedge clk);
        op_sel = 3'(op); acc_in = 8'(a); opnd_in = 8'(b);
        exec_en = ex; sw_wr = wr; sw_wdata = 8'(wd);
        #1;
        e = ref_alu(op, a, b, int'(psw_m[7]), int'(psw_m[6]));
        check({tag, " res"}, res_out, e[13:6]);
        check({tag, " mask"}, flag_we, e[2:0]);
        check({tag, " p_nxt R7"}, p_nxt, ^e[13:6]);
        if (e[2]) check({tag, " cy"}, cy_nxt, e[5]);
        if (e[1]) check({tag, " ac"}, ac_nxt, e[4]);
        if (e[0]) check({tag, " ov"}, ov_nxt, e[3]);
        nx = psw_m;
        if (wr) nx[7:2] = wd[7:2];
        else if (ex) begin
            if (e[2]) nx[7] = e[5];
            if (e[1]) nx[6] = e[4];
            if (e[0]) nx[2] = e[3];
        end
        nx[1] = 1'b0;
        nx[0] = ^a[7:0];
        @(posedge clk); #1;
        check({tag, " psw R9 R10 R8 R7"}, psw_q, nx);
        psw_m = nx;
    endtask

    initial begin : wdog
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int op, a, b, wd;
        int seed;
        seed = 1234;
        void'($urandom(seed));
        // R12: reset with a concurrent software write
        sw_wr = 1'b1; sw_wdata = 8'hFF; acc_in = 8'h01;
        repeat (3) @(posedge clk);
        #1; check("R12 reset", psw_q, 8'h00);
        @(negedge clk); rst = 1'b0; sw_wr = 1'b0;

        // directed corners
        step(0, 8'h7F, 8'h01, 1, 0, 0, "R1 ovf");
        step(0, 8'hFF, 8'h01, 1, 0, 0, "R1 carry");
        step(1, 8'hFF, 8'h00, 1, 0, 0, "R2 cin");      // CY=1 from previous
        step(1, 8'h0E, 8'h01, 1, 0, 0, "R2 half");
        step(0, 8'h00, 8'h00, 1, 1, 8'h80, "R10 set cy");
        step(2, 8'h80, 8'h00, 1, 0, 0, "R3 ovf borrow");
        step(2, 8'h10, 8'h01, 1, 0, 0, "R3 ac");
        step(3, 8'hFF, 8'h00, 1, 0, 0, "R4 inc wrap");
        step(4, 8'h00, 8'h00, 1, 0, 0, "R4 dec wrap");
        step(0, 8'h00, 8'h00, 1, 1, 8'h04, "R10 ov only");
        step(5, 8'h9A, 8'h00, 1, 0, 0, "R5 R6 da 9A");
        step(5, 8'h15, 8'h00, 1, 0, 0, "R6 da keep cy");
        step(0, 8'h00, 8'h00, 1, 1, 8'h40, "R10 ac");
        step(5, 8'h23, 8'h00, 1, 0, 0, "R5 da ac");
        step(0, 8'h80, 8'h80, 1, 1, 8'h00, "R10 prio");
        step(0, 8'h00, 8'h00, 0, 1, 8'hFF, "R8 R7 wr all");
        step(6, 8'h5C, 8'h33, 1, 0, 0, "R11 op6");
        step(7, 8'hA1, 8'h33, 1, 0, 0, "R11 op7");
        step(0, 8'hF0, 8'hF0, 0, 0, 0, "R9 idle");

        for (int i = 0; i < 3000; i++) begin
            op = $urandom_range(0, 7);
            a  = $urandom_range(0, 255);
            b  = $urandom_range(0, 255);
            wd = $urandom_range(0, 255);
            step(op, a, b, ($urandom_range(0, 3) != 0), ($urandom_range(0, 4) == 0),
                 wd, "R1 R2 R3 R4 R5 R6 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule